// File: doc/BRIEF.md
# Keyed Watchdog and Software Reset Generator

This block is a watchdog timer that raises an internal reset pulse when software stops servicing it. A control register on a byte write port selects one of eight timeout periods and turns the counter on. A separate write-only key port accepts two-byte unlock codes. One code restarts the running count. The other asks for an immediate software reset. Any byte pattern on the key port that does not match a valid code is treated as a fault, and it resets the system at once.

Every reset the block raises is the same fixed 16-cycle pulse. The pulse clears the block's own configuration, so the counter is off and the shortest period is selected. Two cause flags record why the reset happened: one for a timeout and one for a software request. These flags survive the pulse. They are cleared only by the external cold reset, or by writing a 0 to their control bits.

Top module: `keyed_watchdog`

## Requirements
- R1: After the cold reset `rst`, all outputs are 0: `period_sel`, `wdt_enable`, `flag_soft`, `flag_overflow` and `core_rst`.
- R2: A control write (`wr_en`=1, `wr_sel`=0) loads `wr_data[2:0]` into `period_sel` and `wr_data[3]` into `wdt_enable`. Both outputs show the new values after that clock edge.
- R3: While enabled, the watchdog raises `core_rst` exactly 16384·2^`period_sel` cycles after the edge that enabled it or last restarted it. A timeout sets `flag_overflow` only.
- R4: A key write (`wr_sel`=1) of 0x1E followed by a key write of 0xE1 restarts the count from zero. When the counter is disabled, this sequence produces no pulse and sets no flag.
- R5: A key write of 0x5A followed by a key write of 0xA5 raises `core_rst` on the edge that samples 0xA5 and sets `flag_soft`. This happens whether or not the watchdog is enabled.
- R6: Some key writes are invalid: a first byte other than 0x1E or 0x5A, or a second byte that does not match its first byte. Each invalid write raises `core_rst` on the edge that samples it and sets both flags.
- R7: Every reset pulse stays high for exactly 16 consecutive cycles.
- R8: A pulse clears `period_sel` and `wdt_enable` and leaves both flags unchanged. Control and key writes made while `core_rst` is high are ignored.
- R9: A control write with `wr_data[4]`=0 clears `flag_soft`, and one with `wr_data[5]`=0 clears `flag_overflow`. Writing 1 to either bit leaves that flag as it was, and a write can never set a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also clocks the watchdog counter |
| rst | input | 1 | Synchronous active-high cold reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = key port |
| wr_data | input | 8 | Write data byte |
| period_sel | output | 3 | Selected timeout period index |
| wdt_enable | output | 1 | Watchdog counter enabled |
| flag_soft | output | 1 | Sticky flag: software or invalid-key reset occurred |
| flag_overflow | output | 1 | Sticky flag: timeout or invalid-key reset occurred |
| core_rst | output | 1 | 16-cycle internal reset pulse |

## Verification
The assertions assume the write port carries defined values whenever `wr_en` is high, and that each write is a single-cycle strobe. They also assume `rst` is held high from time zero until the first write. The stimulus meets these assumptions: it drives one write at a time on the falling clock edge, always drops `wr_en` for a cycle between writes, and holds `wr_en` low throughout the cold reset. Writes made during a pulse are deliberate. They check that such writes are ignored, and the assertions allow for them because they disable the write path while `core_rst` is high.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ARM_KICK,
    KS_ARM_SOFT
  } key_state_t;

  localparam logic [7:0] KICK_FIRST  = 8'h1E;
  localparam logic [7:0] KICK_SECOND = 8'hE1;
  localparam logic [7:0] SOFT_FIRST  = 8'h5A;
  localparam logic [7:0] SOFT_SECOND = 8'hA5;

  localparam int CTRL_EN_BIT   = 3;
  localparam int CTRL_SOFT_BIT = 4;
  localparam int CTRL_OV_BIT   = 5;

endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       kick_o,
  output logic       soft_o,
  output logic       bad_o
);

  key_state_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    kick_o = 1'b0;
    soft_o = 1'b0;
    bad_o  = 1'b0;
    if (wr_i) begin
      case (st_q)
        KS_IDLE: begin
          if (data_i == KICK_FIRST)      st_d = KS_ARM_KICK;
          else if (data_i == SOFT_FIRST) st_d = KS_ARM_SOFT;
          else                           bad_o = 1'b1;
        end
        KS_ARM_KICK: begin
          st_d = KS_IDLE;
          if (data_i == KICK_SECOND) kick_o = 1'b1;
          else                       bad_o  = 1'b1;
        end
        KS_ARM_SOFT: begin
          st_d = KS_IDLE;
          if (data_i == SOFT_SECOND) soft_o = 1'b1;
          else                       bad_o  = 1'b1;
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr_i) st_q <= KS_IDLE;
    else       st_q <= st_d;
  end

  // R6: at most one outcome per key write
  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (clr_i)
    $onehot0({kick_o, soft_o, bad_o}));

  // R4: an armed state only lasts until the next write
  assert_arm_consumed_R4: assert property (@(posedge clk) disable iff (clr_i)
    (wr_i && st_q != KS_IDLE) |=> st_q == KS_IDLE);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int BASE_LOG2 = 14,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             timeout_o
);

  localparam int CW = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb begin
    limit     = (CW'(1) << (BASE_LOG2 + int'(sel_i))) - CW'(1);
    timeout_o = en_i && (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (clr_i || restart_i || !en_i) cnt_q <= '0;
    else                             cnt_q <= cnt_q + CW'(1);
  end

  // R3: an enabled, undisturbed counter advances by one each cycle
  assert_count_advance_R3: assert property (@(posedge clk) disable iff (clr_i)
    (en_i && !restart_i && !timeout_o) |=> (clr_i || cnt_q == $past(cnt_q) + CW'(1)));

  // R4: a restart returns the count to zero
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (clr_i)
    restart_i |=> cnt_q == '0);

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic active_o
);

  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_o) begin
      if (trig_i) begin
        active_o <= 1'b1;
        cnt_q    <= '0;
      end
    end else begin
      cnt_q <= cnt_q + PW'(1);
      if (cnt_q == PW'(LEN - 1)) active_o <= 1'b0;
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic [SEL_W-1:0] period_sel,
  output logic             wdt_enable,
  output logic             flag_soft,
  output logic             flag_overflow,
  output logic             core_rst
);

  localparam int RW = $clog2(PULSE_LEN + 1) + 1;

  logic busy;
  logic ctrl_wr, key_wr, blk_clr;
  logic kick, soft_req, bad_key, timeout, trigger;

  assign ctrl_wr = wr_en && !wr_sel && !busy;
  assign key_wr  = wr_en &&  wr_sel && !busy;
  assign blk_clr = rst || busy;
  assign trigger = timeout || soft_req || bad_key;

  wdk_keyseq u_keys (
    .clk    (clk),
    .clr_i  (blk_clr),
    .wr_i   (key_wr),
    .data_i (wr_data),
    .kick_o (kick),
    .soft_o (soft_req),
    .bad_o  (bad_key)
  );

  wdk_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_count (
    .clk       (clk),
    .clr_i     (blk_clr),
    .en_i      (wdt_enable),
    .sel_i     (period_sel),
    .restart_i (kick),
    .timeout_o (timeout)
  );

  wdk_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trigger),
    .active_o (busy)
  );

  always_ff @(posedge clk) begin
    if (rst || trigger || busy) begin
      period_sel <= '0;
      wdt_enable <= 1'b0;
    end else if (ctrl_wr) begin
      period_sel <= wr_data[SEL_W-1:0];
      wdt_enable <= wr_data[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_soft     <= 1'b0;
      flag_overflow <= 1'b0;
    end else begin
      flag_soft     <= (flag_soft && !(ctrl_wr && !wr_data[CTRL_SOFT_BIT]))
                       || soft_req || bad_key;
      flag_overflow <= (flag_overflow && !(ctrl_wr && !wr_data[CTRL_OV_BIT]))
                       || timeout || bad_key;
    end
  end

  assign core_rst = busy;

  // Checker state: length of the current pulse run
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !core_rst) run_q <= '0;
    else                  run_q <= run_q + RW'(1);
  end

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> run_q < RW'(PULSE_LEN));

  assert_pulse_full_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(run_q) == RW'(PULSE_LEN - 1));

  assert_cfg_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (!wdt_enable && period_sel == '0));

  assert_cause_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> (flag_soft || flag_overflow));

  assert_soft_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_soft && !(ctrl_wr && !wr_data[CTRL_SOFT_BIT])) |=> flag_soft);

  assert_ov_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_overflow && !(ctrl_wr && !wr_data[CTRL_OV_BIT])) |=> flag_overflow);

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !trigger) |=> wdt_enable == $past(wr_data[CTRL_EN_BIT]));

endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;

  localparam longint BASE   = 16384;
  localparam longint WD_MAX = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] period_sel;
  logic       wdt_enable, flag_soft, flag_overflow, core_rst;

  keyed_watchdog u_keyed_watchdog (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .period_sel (period_sel), .wdt_enable (wdt_enable), .flag_soft (flag_soft),
    .flag_overflow (flag_overflow), .core_rst (core_rst)
  );

  always #4 clk = ~clk;

  typedef struct { longint at; bit sw; bit ov; } ev_t;
  ev_t    ev_q[$];
  longint cyc = 0;
  int     errors = 0;
  int     checks = 0;
  logic   prev_rst = 1'b0;
  int     run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor: pops expected pulses and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (core_rst && !prev_rst) begin
        if (ev_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected pulse at cycle", cyc, -1);
        end else begin
          ev_t e;
          e = ev_q.pop_front();
          chk(cyc == e.at, "R3", "pulse start cycle", cyc, e.at);
          chk(flag_soft == e.sw, "R5", "soft flag at pulse", flag_soft, e.sw);
          chk(flag_overflow == e.ov, "R6", "overflow flag at pulse", flag_overflow, e.ov);
        end
        run = 1;
      end else if (core_rst) begin
        run++;
      end
      if (!core_rst && prev_rst) chk(run == 16, "R7", "pulse length", run, 16);
      prev_rst = core_rst;
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_MAX) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected<%0d", cyc, WD_MAX);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d, output longint e);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: pushes the expected pulse before the edge that raises it
  task automatic wr_ev(input logic sel, input logic [7:0] d, input bit sw, input bit ov);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    ev_q.push_back('{cyc + 1, sw, ov});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (ev_q.size() == 0 && !core_rst && !prev_rst) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    longint e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(period_sel == 0 && !wdt_enable, "R1", "config after reset", {period_sel, wdt_enable}, 0);
    chk(!flag_soft && !flag_overflow && !core_rst, "R1", "flags/pulse after reset",
        {flag_soft, flag_overflow, core_rst}, 0);

    // R2 control load
    wr(1'b0, 8'h0B, e);
    chk(period_sel == 3, "R2", "period_sel", period_sel, 3);
    chk(wdt_enable == 1, "R2", "enable", wdt_enable, 1);
    wr(1'b0, 8'h00, e);
    chk(wdt_enable == 0, "R2", "enable cleared", wdt_enable, 0);

    // R9 writing ones never sets flags
    wr(1'b0, 8'h30, e);
    chk(!flag_soft && !flag_overflow, "R9", "flags after write of ones",
        {flag_soft, flag_overflow}, 0);

    // R5 software reset while disabled
    wr(1'b1, 8'h5A, e);
    wr_ev(1'b1, 8'hA5, 1'b1, 1'b0);
    wait_idle(100);
    chk(flag_soft == 1 && flag_overflow == 0, "R8", "flags survive pulse",
        {flag_soft, flag_overflow}, 2);
    // R9 clear semantics
    wr(1'b0, 8'h10, e);
    chk(flag_soft == 1, "R9", "soft kept by 1", flag_soft, 1);
    wr(1'b0, 8'h00, e);
    chk(flag_soft == 0, "R9", "soft cleared by 0", flag_soft, 0);

    // R6 invalid first byte
    wr_ev(1'b1, 8'h33, 1'b1, 1'b1);
    wait_idle(100);
    wr(1'b0, 8'h00, e);
    chk(!flag_soft && !flag_overflow, "R9", "both flags cleared",
        {flag_soft, flag_overflow}, 0);

    // R6 wrong second byte after kick prefix
    wr(1'b1, 8'h1E, e);
    wr_ev(1'b1, 8'h5A, 1'b1, 1'b1);
    wait_idle(100);
    wr(1'b0, 8'h00, e);

    // R6 wrong second byte after soft prefix
    wr(1'b1, 8'h5A, e);
    wr_ev(1'b1, 8'h5A, 1'b1, 1'b1);
    wait_idle(100);
    wr(1'b0, 8'h00, e);

    // R5 software reset while enabled; R8 config cleared
    wr(1'b0, 8'h0F, e);
    chk(wdt_enable == 1 && period_sel == 7, "R2", "config 0x0F", {period_sel, wdt_enable}, 15);
    wr(1'b1, 8'h5A, e);
    wr_ev(1'b1, 8'hA5, 1'b1, 1'b0);
    wait_idle(100);
    chk(period_sel == 0 && !wdt_enable, "R8", "config after pulse", {period_sel, wdt_enable}, 0);
    wr(1'b0, 8'h00, e);

    // R8 writes during pulse are ignored
    wr_ev(1'b1, 8'h00, 1'b1, 1'b1);
    wr(1'b0, 8'h0B, e);
    wr(1'b1, 8'h44, e);
    wait_idle(100);
    chk(period_sel == 0 && !wdt_enable, "R8", "config write during pulse", {period_sel, wdt_enable}, 0);
    chk(flag_soft && flag_overflow, "R8", "flags kept during pulse writes",
        {flag_soft, flag_overflow}, 3);
    wr(1'b0, 8'h00, e);

    // R4 restart sequence while disabled does nothing
    wr(1'b1, 8'h1E, e);
    wr(1'b1, 8'hE1, e);
    repeat (20) @(negedge clk);
    chk(!core_rst && !flag_soft && !flag_overflow, "R4", "disabled restart side effects",
        {core_rst, flag_soft, flag_overflow}, 0);

    // R3 timeout at shortest period
    wr(1'b0, 8'h08, e);
    ev_q.push_back('{e + BASE, 1'b0, 1'b1});
    wait_idle(20000);
    chk(!wdt_enable, "R8", "enable after timeout", wdt_enable, 0);
    chk(flag_overflow && !flag_soft, "R3", "overflow flag only", {flag_soft, flag_overflow}, 1);
    wr(1'b0, 8'h00, e);

    // R4 restart postpones the timeout
    wr(1'b0, 8'h08, e);
    repeat (10000) @(negedge clk);
    wr(1'b1, 8'h1E, e);
    wr(1'b1, 8'hE1, e);
    ev_q.push_back('{e + BASE, 1'b0, 1'b1});
    wait_idle(20000);
    wr(1'b0, 8'h00, e);

    // R3 second period select
    wr(1'b0, 8'h09, e);
    ev_q.push_back('{e + 2 * BASE, 1'b0, 1'b1});
    wait_idle(40000);

    chk(ev_q.size() == 0, "R3", "pending expected pulses", ev_q.size(), 0);
    summary();
    $finish;
  end

endmodule